// File: doc/BRIEF.md
# One-Wire Pulse-Width Programming Encoder

This host-side block turns a six-bit output pattern into the single-wire programming waveform that a remote latch chain decodes. A start request copies the pattern into the block. The block then sends one fixed-length frame per bit, with bit 0 first. Each frame opens with a low setup interval. The bit value is carried only by how long the line then stays high. A bit of 1 gives a long high pulse and a bit of 0 gives a short one, so a receiver that samples the line a fixed time after the rising edge reads the bit directly.

All timing is counted in ticks of the `usTick` strobe, which is nominally one microsecond. A setup of 50 ticks, a short pulse of 50 ticks and a long pulse of 200 ticks give every frame the same length of 250 ticks, and a full word takes 1500 ticks. Every request sends all six frames, even when only one remote output would change. When the last frame ends, the line goes low and stays low so the remote outputs are not disturbed. `busy` covers the whole word, and `done` marks its end.

Top module: `pw_line_encoder`

## Requirements
- R1: Every frame lasts exactly 250 ticks (frame `k` covers ticks 250k+1 to 250k+250 after the accepted start). For the first 50 ticks of each frame `serOut` is low.
- R2: A bit of value 1 drives `serOut` high for 200 ticks, from the end of the setup interval up to the end of its frame.
- R3: A bit of value 0 drives `serOut` high for 50 ticks after the setup interval, then low for the remaining 150 ticks of its frame.
- R4: Frames carry `dataIn` bit 0 first and bit 5 last. Frame `k` carries bit `k` of the captured word.
- R5: A start is accepted only while `busy` is low. The word is captured on the clock edge that accepts it. Later changes on `dataIn` and `start` while `busy` is high do not alter the waveform.
- R6: After the last frame, `serOut` is low and stays low while idle, even while ticks keep arriving.
- R7: `busy` rises on the edge that accepts a start and falls on the edge that counts tick 1500. `done` is high for exactly that one clock.
- R8: During reset and right after it, `serOut`, `busy` and `done` are low. A reset in the middle of a word drops all three.
- R9: Sending the same word twice in a row produces two complete six-frame words.
- R10: Only clock cycles with `usTick` high advance the waveform. Without ticks, `serOut` holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | One-clock timing strobe, one per microsecond |
| start | input | 1 | Request to send the word on `dataIn` |
| dataIn | input | 6 | Output pattern, bit 0 sent first |
| busy | output | 1 | High while a word is being sent |
| done | output | 1 | One-clock pulse at the end of a word |
| serOut | output | 1 | Serial programming line |

## Verification
The bench compares the line after every tick against a model of the frame rule, across patterns that include all zeros, all ones, a single bit set at each end, and two mixed words. A bit order reversed, a pulse one tick short or long, or a setup counted off by one shows up as a mismatch at a known tick. In the middle of one word the bench pulses `start` again and inverts `dataIn`. A design that re-armed or read the input live would distort the remaining frames. Further tests target a line left high after a final 1 bit, a `done` that lasts more than one clock or comes at the wrong tick, a repeated word, a stall with no ticks, and a reset in the middle of a word.

// File: rtl/pw_line_pkg.sv
`timescale 1ns/1ps
package pw_line_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture word, restart frame counter
    logic step;     // advance frame counter by one tick
    logic nextBit;  // move to next bit, restart frame counter
    logic stop;     // word finished, park line low
  } ctlStrobe_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} encState_t;
endpackage

// File: rtl/pw_line_datapath.sv
`timescale 1ns/1ps
module pw_line_datapath
  import pw_line_pkg::*;
#(
  parameter int NUM_BITS    = 6,
  parameter int SETUP_TICKS = 50,
  parameter int SHORT_TICKS = 50,
  parameter int LONG_TICKS  = 200
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [NUM_BITS-1:0] dataIn,
  output logic                frameEnd,
  output logic                serOut
);
  localparam int FRAME_TICKS = SETUP_TICKS + LONG_TICKS;
  localparam int CNT_W = $clog2(FRAME_TICKS + 1);
  localparam logic [CNT_W-1:0] SETUP_C = CNT_W'(SETUP_TICKS);
  localparam logic [CNT_W-1:0] SHORT_END = CNT_W'(SETUP_TICKS + SHORT_TICKS);
  localparam logic [CNT_W-1:0] LONG_END = CNT_W'(SETUP_TICKS + LONG_TICKS);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_TICKS - 1);

  logic [CNT_W-1:0]    cntQ, cntN;
  logic [NUM_BITS-1:0] shQ, shN;
  logic                lineQ, lineN;
  logic [CNT_W-1:0]    highEnd;

  assign highEnd  = shQ[0] ? LONG_END : SHORT_END;
  assign frameEnd = (cntQ == LAST_C);

  always_comb begin
    cntN  = cntQ;
    shN   = shQ;
    lineN = lineQ;
    if (ctl.load) begin
      cntN  = '0;
      shN   = dataIn;
      lineN = 1'b0;
    end else if (ctl.nextBit) begin
      cntN  = '0;
      shN   = shQ >> 1;
      lineN = 1'b0;
    end else if (ctl.stop) begin
      cntN  = '0;
      lineN = 1'b0;
    end else if (ctl.step) begin
      cntN  = cntQ + 1'b1;
      lineN = (cntN >= SETUP_C) && (cntN < highEnd);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      shQ   <= '0;
      lineQ <= 1'b0;
    end else begin
      cntQ  <= cntN;
      shQ   <= shN;
      lineQ <= lineN;
    end
  end

  assign serOut = lineQ;
endmodule

// File: rtl/pw_line_control.sv
`timescale 1ns/1ps
module pw_line_control
  import pw_line_pkg::*;
#(
  parameter int NUM_BITS = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       start,
  input  logic       frameEnd,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       done
);
  localparam int IDX_W = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BITS - 1);

  encState_t        stateQ, stateN;
  logic [IDX_W-1:0] bitIdxQ, bitIdxN;
  logic             doneQ, doneN;

  always_comb begin
    ctl     = '0;
    stateN  = stateQ;
    bitIdxN = bitIdxQ;
    doneN   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          stateN   = ST_RUN;
          bitIdxN  = '0;
        end
      end
      ST_RUN: begin
        if (usTick) begin
          if (frameEnd) begin
            if (bitIdxQ == LAST_IDX) begin
              ctl.stop = 1'b1;
              stateN   = ST_IDLE;
              doneN    = 1'b1;
            end else begin
              ctl.nextBit = 1'b1;
              bitIdxN     = bitIdxQ + 1'b1;
            end
          end else begin
            ctl.step = 1'b1;
          end
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      bitIdxQ <= '0;
      doneQ   <= 1'b0;
    end else begin
      stateQ  <= stateN;
      bitIdxQ <= bitIdxN;
      doneQ   <= doneN;
    end
  end

  assign busy = (stateQ == ST_RUN);
  assign done = doneQ;
endmodule

// File: rtl/pw_line_encoder.sv
`timescale 1ns/1ps
module pw_line_encoder
  import pw_line_pkg::*;
#(
  parameter int NUM_BITS    = 6,
  parameter int SETUP_TICKS = 50,
  parameter int SHORT_TICKS = 50,
  parameter int LONG_TICKS  = 200
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                usTick,
  input  logic                start,
  input  logic [NUM_BITS-1:0] dataIn,
  output logic                busy,
  output logic                done,
  output logic                serOut
);
  ctlStrobe_t ctl;
  logic       frameEnd;

  pw_line_control #(.NUM_BITS(NUM_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .start(start),
    .frameEnd(frameEnd), .ctl(ctl), .busy(busy), .done(done)
  );

  pw_line_datapath #(
    .NUM_BITS(NUM_BITS), .SETUP_TICKS(SETUP_TICKS),
    .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn),
    .frameEnd(frameEnd), .serOut(serOut)
  );
endmodule

// File: rtl/pw_line_encoder_chk.sv
`timescale 1ns/1ps
module pw_line_encoder_chk (
  input logic clk,
  input logic rstN,
  input logic usTick,
  input logic start,
  input logic busy,
  input logic done,
  input logic serOut
);
  p_idle_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !serOut);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_accept_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  p_tick_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !usTick) |=> $stable(serOut));

  p_rise_on_tick_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serOut) |-> $past(usTick));
endmodule

bind pw_line_encoder pw_line_encoder_chk chk_i (
  .clk(clk), .rstN(rstN), .usTick(usTick), .start(start),
  .busy(busy), .done(done), .serOut(serOut)
);

// File: tb/pw_line_encoder_tb_top.sv
`timescale 1ns/1ps
module pw_line_encoder_tb_top;
  localparam int WORD_TICKS = 1500;
  localparam int FRAME = 250;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b0;
  logic start = 1'b0;
  logic [5:0] dataIn = '0;
  logic busy, done, serOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pw_line_encoder dut_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .start(start),
    .dataIn(dataIn), .busy(busy), .done(done), .serOut(serOut)
  );

  // {word, expected number of high ticks}
  localparam logic [17:0] VEC [6] = '{
    {6'b000000, 12'd300},
    {6'b111111, 12'd1200},
    {6'b010100, 12'd600},
    {6'b011100, 12'd750},
    {6'b000001, 12'd450},
    {6'b100000, 12'd450}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic expLevel(input logic [5:0] w, input int t);
    int f, p;
    if (t >= WORD_TICKS) return 1'b0;
    f = t / FRAME;
    p = t % FRAME;
    return (p >= 50) && (p < 50 + (w[f] ? 200 : 50));
  endfunction

  // one tick, then sample away from the edge
  task automatic stepTick();
    @(negedge clk) usTick = 1'b1;
    @(negedge clk) usTick = 1'b0;
  endtask

  task automatic idleClocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runWord(input logic [5:0] w, input int expHigh, input bit poke);
    int mism, firstBad, highCnt, ctlBad;
    mism = 0; firstBad = -1; highCnt = 0; ctlBad = 0;
    @(negedge clk) begin start = 1'b1; dataIn = w; end
    @(negedge clk) start = 1'b0;
    check(busy && !serOut && !done, "R7 busy on accept", {busy, serOut, done}, 3'b100);
    for (int t = 1; t <= WORD_TICKS; t++) begin
      stepTick();
      if (serOut !== expLevel(w, t)) begin
        mism++;
        if (firstBad < 0) firstBad = t;
      end
      if (serOut === 1'b1) highCnt++;
      if (t < WORD_TICKS && (busy !== 1'b1 || done !== 1'b0)) ctlBad++;
      if (t == WORD_TICKS && (busy !== 1'b0 || done !== 1'b1)) ctlBad++;
      if (poke && t == 300) begin
        @(negedge clk) begin start = 1'b1; dataIn = ~w; end
        @(negedge clk) start = 1'b0;
      end
      idleClocks(2);
      if (t == WORD_TICKS) check(done === 1'b0, "R7 done one clock", done, 0);
    end
    check(mism == 0, poke ? "R5 R1 R2 R3 R4 waveform with input poke" : "R1 R2 R3 R4 waveform",
          firstBad, -1);
    check(highCnt == expHigh, "R2 R3 high tick total", highCnt, expHigh);
    check(ctlBad == 0, "R7 busy/done timing", ctlBad, 0);
    highCnt = 0;
    for (int k = 0; k < 20; k++) begin
      stepTick();
      if (serOut !== 1'b0 || busy !== 1'b0) highCnt++;
    end
    check(highCnt == 0, "R6 line low after word", highCnt, 0);
  endtask

  initial begin
    int cnt;
    idleClocks(3);
    check(serOut === 1'b0 && busy === 1'b0 && done === 1'b0, "R8 reset state",
          {serOut, busy, done}, 0);
    rstN = 1'b1;
    idleClocks(2);
    check(serOut === 1'b0 && busy === 1'b0 && done === 1'b0, "R8 after release",
          {serOut, busy, done}, 0);
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      stepTick();
      if (serOut !== 1'b0) cnt++;
    end
    check(cnt == 0, "R6 idle ticks keep line low", cnt, 0);

    foreach (VEC[i])
      runWord(VEC[i][17:12], int'(VEC[i][11:0]), i == 2);

    // R9: same word twice, back to back
    runWord(6'b011100, 750, 1'b0);
    runWord(6'b011100, 750, 1'b0);

    // R10: no ticks, no progress
    @(negedge clk) begin start = 1'b1; dataIn = 6'b000001; end
    @(negedge clk) start = 1'b0;
    for (int t = 1; t <= 60; t++) stepTick();
    cnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (serOut !== 1'b1 || busy !== 1'b1) cnt++;
    end
    check(cnt == 0, "R10 stall holds line high", cnt, 0);

    // R8: reset mid-word
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    check(serOut === 1'b0 && busy === 1'b0 && done === 1'b0, "R8 mid-word reset",
          {serOut, busy, done}, 0);
    rstN = 1'b1;
    idleClocks(2);
    runWord(6'b101010, 750, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule